// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns single-cycle host write requests into correctly timed write cycles on an asynchronous byte-wide static RAM. It owns the memory's address bus, data bus, an output-enable flag for its own data driver, and the active-low write-enable and chip-enable strobes. It places every edge on a system clock. All memory timing limits are given as nanosecond parameters and are turned into clock counts by rounding up, with a floor of one cycle.

Two strobe styles are offered and chosen per request by a mode input. In write-enable style, chip-enable drops first and the write-enable pulse ends the cycle. The data driver stays off until the memory's outputs have had time to float. In chip-enable style, both strobes fall together, so the memory never drives the bus and data goes out at once. Chip-enable rising ends the cycle. After the ending edge, the block holds address, data and the other strobe. It then pads out the minimum cycle time and returns to idle. There it raises ready and pulses done.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, ready is 1, done is 0, both strobes are 1 (inactive) and the data driver flag is 0.
- R2: Ready is 1 only while the sequencer is idle. A request is taken at the clock edge where req_valid and ready are both 1, and ready reads 0 from the next cycle until the write completes.
- R3: The address and data of a taken request appear on mem_addr and mem_dout in the cycle after acceptance. They stay unchanged until the next request is taken.
- R4: Every interval is ceil(ns*1000/CLK_PS) cycles, and never less than 1. The ending strobe stays low for a fixed length in each style. In write-enable style the length is the largest of the pulse width, the address setup, and the float time plus the data setup. In chip-enable style it is the largest of the pulse width, the address setup and the data setup. With the defaults this is 26 cycles for write-enable style and 20 for chip-enable style.
- R5: Write-enable style (req_ce_mode = 0) runs as follows.
  - Chip-enable is low from the first cycle after acceptance.
  - Write-enable falls one cycle later.
  - The data driver stays off for the first ceil(float) cycles of the write-enable pulse (13 by default), then turns on.
  - Chip-enable stays low through the hold interval, so it is low for 30 cycles by default.
- R6: Chip-enable style (req_ce_mode = 1) runs as follows.
  - Both strobes fall in the second cycle after acceptance.
  - The data driver is on from that same cycle.
  - Chip-enable rises first, and write-enable stays low through the hold interval.
- R7: After the ending strobe rises, the data driver, the data and the other strobe are held for the larger of the address hold and the data hold (3 cycles by default). All of them are then released in the same cycle.
- R8: Address changes of successive accepted requests are at least ceil(cycle time) cycles apart. The busy time is 1 + strobe + hold + recovery cycles, where recovery is max(1, cycle − strobe − hold − 2). By default the busy time is 31 cycles in write-enable style and 25 in chip-enable style.
- R9: Done is 1 for exactly one cycle, the cycle in which ready returns to 1.
- R10: A request made while busy is not taken and does not change the address, data, strobes or timing of the running write. If the host holds it, it is taken at the end of the cycle in which ready returns.
- R11: The style input is sampled only at acceptance. Changing it while busy has no effect on the running write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host write request, held until taken |
| req_addr | input | ADDR_W | Target address |
| req_data | input | DATA_W | Byte to write |
| req_ce_mode | input | 1 | 1 = chip-enable ends the cycle, 0 = write-enable ends it |
| rdy | output | 1 | Sequencer idle, request can be taken |
| done | output | 1 | One-cycle pulse at write completion |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dout | output | DATA_W | Memory write data |
| mem_dout_en | output | 1 | Data driver enable flag |
| mem_we_n | output | 1 | Active-low write-enable |
| mem_ce_n | output | 1 | Active-low chip-enable |

## Verification
Completion and acceptance of the next request fall in the same cycle. Done and ready rise together, and a request held by the host is taken at the end of that same cycle. Back-to-back tests provoke this by keeping req_valid high, with a different address and style, through a whole running write. The bench judges it in three ways:
- The running write keeps its own address and strobe counts.
- The new address appears exactly one cycle after the done pulse.
- The gap between the two address changes is no shorter than the cycle time.

// File: rtl/sramw_pkg.sv
`timescale 1ns/1ps
package sramw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_RECOVER
  } seq_state_t;

  // Round a nanosecond limit up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramw_ticker.sv
`timescale 1ns/1ps
module sramw_ticker #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sramw_capture.sv
`timescale 1ns/1ps
module sramw_capture #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              mode_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
      mode_q <= 1'b0;
    end else if (load) begin
      addr_q <= addr_in;
      data_q <= data_in;
      mode_q <= mode_in;
    end
  end
endmodule

// File: rtl/sramw_fsm.sv
`timescale 1ns/1ps
module sramw_fsm
  import sramw_pkg::*;
#(
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned NS_WE  = 26,
  parameter int unsigned NS_CE  = 20,
  parameter int unsigned NH     = 3,
  parameter int unsigned NR_WE  = 1,
  parameter int unsigned NR_CE  = 1,
  parameter int unsigned NFLOAT = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_mode_ce,
  input  logic mode_ce,
  output logic accept,
  output logic rdy,
  output logic done,
  output logic we_n,
  output logic ce_n,
  output logic dout_en
);
  seq_state_t st, st_nx;
  logic [CNT_W-1:0] cnt;
  logic strobe_end, hold_end, rec_end, float_end;

  sramw_ticker #(.W(CNT_W)) u_tick (
    .clk(clk), .rst(rst), .clr(st_nx != st), .cnt(cnt)
  );

  assign strobe_end = (cnt == (mode_ce ? CNT_W'(NS_CE - 1) : CNT_W'(NS_WE - 1)));
  assign hold_end   = (cnt == CNT_W'(NH - 1));
  assign rec_end    = (cnt == (mode_ce ? CNT_W'(NR_CE - 1) : CNT_W'(NR_WE - 1)));
  assign float_end  = (cnt == CNT_W'(NFLOAT - 1));
  assign accept     = (st == ST_IDLE) && req_valid;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:    if (req_valid)  st_nx = ST_SETUP;
      ST_SETUP:                   st_nx = ST_STROBE;
      ST_STROBE:  if (strobe_end) st_nx = ST_HOLD;
      ST_HOLD:    if (hold_end)   st_nx = ST_RECOVER;
      ST_RECOVER: if (rec_end)    st_nx = ST_IDLE;
      default:                    st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      rdy     <= 1'b1;
      done    <= 1'b0;
      we_n    <= 1'b1;
      ce_n    <= 1'b1;
      dout_en <= 1'b0;
    end else begin
      st   <= st_nx;
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          rdy  <= 1'b0;
          ce_n <= req_mode_ce;       // write-enable style opens chip-enable early
        end
        ST_SETUP: begin
          we_n    <= 1'b0;
          ce_n    <= 1'b0;
          dout_en <= mode_ce;        // both strobes fall together: bus already quiet
        end
        ST_STROBE: begin
          if (!mode_ce && float_end) dout_en <= 1'b1;
          if (strobe_end) begin
            if (mode_ce) ce_n <= 1'b1;
            else         we_n <= 1'b1;
          end
        end
        ST_HOLD: if (hold_end) begin
          we_n    <= 1'b1;
          ce_n    <= 1'b1;
          dout_en <= 1'b0;
        end
        ST_RECOVER: if (rec_end) begin
          rdy  <= 1'b1;
          done <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R2: a taken request drops ready on the following cycle
  p_accept_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && rdy) |=> !rdy);
  // R9: completion pulse lasts one cycle and coincides with ready
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (rdy && $past(!rdy)));
  // R5: in write-enable style the write strobe never leads chip-enable
  p_we_inside_ce_r5: assert property (@(posedge clk) disable iff (rst)
    (!mode_ce && !we_n) |-> !ce_n);
  // R6: in chip-enable style both strobes fall in one cycle
  p_same_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_ce && $fell(ce_n)) |-> ($fell(we_n) && dout_en));
  // R7: data still driven when the ending strobe rises
  p_data_at_rise_r7: assert property (@(posedge clk) disable iff (rst)
    ((!mode_ce && $rose(we_n)) || (mode_ce && $rose(ce_n))) |-> dout_en);
endmodule

// File: rtl/sram_wr_seq.sv
`timescale 1ns/1ps
module sram_wr_seq
  import sramw_pkg::*;
#(
  parameter int unsigned ADDR_W          = 15,
  parameter int unsigned DATA_W          = 8,
  parameter int unsigned CLK_PS          = 4000,
  parameter int unsigned T_CYCLE_NS      = 100,
  parameter int unsigned T_PULSE_NS      = 80,
  parameter int unsigned T_ADDR_SETUP_NS = 80,
  parameter int unsigned T_DATA_SETUP_NS = 50,
  parameter int unsigned T_DATA_HOLD_NS  = 5,
  parameter int unsigned T_ADDR_HOLD_NS  = 10,
  parameter int unsigned T_FLOAT_NS      = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_ce_mode,
  output logic              rdy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  output logic              mem_we_n,
  output logic              mem_ce_n
);
  localparam int unsigned C_CYC   = ns_to_cyc(T_CYCLE_NS, CLK_PS);
  localparam int unsigned C_PULSE = ns_to_cyc(T_PULSE_NS, CLK_PS);
  localparam int unsigned C_ASU   = ns_to_cyc(T_ADDR_SETUP_NS, CLK_PS);
  localparam int unsigned C_DSU   = ns_to_cyc(T_DATA_SETUP_NS, CLK_PS);
  localparam int unsigned C_DH    = ns_to_cyc(T_DATA_HOLD_NS, CLK_PS);
  localparam int unsigned C_AH    = ns_to_cyc(T_ADDR_HOLD_NS, CLK_PS);
  localparam int unsigned C_FLOAT = ns_to_cyc(T_FLOAT_NS, CLK_PS);

  localparam int unsigned NS_WE = umax(umax(C_PULSE, C_ASU), C_FLOAT + C_DSU);
  localparam int unsigned NS_CE = umax(umax(C_PULSE, C_ASU), C_DSU);
  localparam int unsigned NH    = umax(C_AH, C_DH);
  localparam int unsigned NR_WE = (C_CYC >= NS_WE + NH + 3) ? C_CYC - NS_WE - NH - 2 : 1;
  localparam int unsigned NR_CE = (C_CYC >= NS_CE + NH + 3) ? C_CYC - NS_CE - NH - 2 : 1;
  localparam int unsigned C_MAX = umax(umax(NS_WE, NS_CE), umax(NH, umax(NR_WE, NR_CE)));
  localparam int unsigned CNT_W = $clog2(C_MAX + 1);
  localparam int unsigned CHK_W = $clog2(4 * C_MAX + 4) + 1;

  logic accept, mode_q;

  sramw_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .load(accept),
    .addr_in(req_addr), .data_in(req_data), .mode_in(req_ce_mode),
    .addr_q(mem_addr), .data_q(mem_dout), .mode_q(mode_q)
  );

  sramw_fsm #(
    .CNT_W(CNT_W), .NS_WE(NS_WE), .NS_CE(NS_CE), .NH(NH),
    .NR_WE(NR_WE), .NR_CE(NR_CE), .NFLOAT(C_FLOAT)
  ) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode_ce(req_ce_mode),
    .mode_ce(mode_q), .accept(accept), .rdy(rdy), .done(done),
    .we_n(mem_we_n), .ce_n(mem_ce_n), .dout_en(mem_dout_en)
  );

  // Checker state: low run of the ending strobe, cycles since last acceptance.
  logic [CHK_W-1:0] low_run, acc_gap;
  logic             term_n;
  assign term_n = mode_q ? mem_ce_n : mem_we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run <= '0;
      acc_gap <= '1;
    end else begin
      if (term_n)          low_run <= '0;
      else if (~&low_run)  low_run <= low_run + 1'b1;
      if (accept)          acc_gap <= CHK_W'(1);
      else if (~&acc_gap)  acc_gap <= acc_gap + 1'b1;
    end
  end

  // R3: address frozen while a write runs
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!rdy && $past(!rdy)) |-> $stable(mem_addr));
  // R4: ending strobe pulse no shorter than the pulse width
  p_strobe_min_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(term_n) |-> (low_run >= CHK_W'(C_PULSE)));
  // R8: address changes spaced by the cycle time
  p_cycle_min_r8: assert property (@(posedge clk) disable iff (rst)
    accept |-> (acc_gap >= CHK_W'(C_CYC)));
endmodule

// File: tb/sim_sram_wr_seq.sv
`timescale 1ns/1ps
module sim_sram_wr_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [14:0] req_addr;
  logic [7:0]  req_data;
  logic        req_ce_mode;
  logic        rdy, done, dout_en, we_n, ce_n;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dout;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sram_wr_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_ce_mode(req_ce_mode), .rdy(rdy), .done(done),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(dout_en),
    .mem_we_n(we_n), .mem_ce_n(ce_n)
  );

  function automatic int cdiv(input int ns);
    return (ns * 1000 + 3999) / 4000;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected intervals from the requirements at a 4 ns clock.
  localparam int E_CYC   = (100 * 1000 + 3999) / 4000;
  int e_float, e_ns_we, e_ns_ce, e_nh, e_busy_we, e_busy_ce;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Samples one running write from its first busy cycle to the cycle ready returns.
  task automatic measure(input logic [14:0] a, input logic [7:0] d, input bit ce, output int busy);
    int idx = 0, we_lo = 0, ce_lo = 0, dv = 0;
    int we_first = -1, ce_first = -1, dv_first = -1, addr_bad = 0, data_bad = 0;
    int ns, term;
    ns = ce ? e_ns_ce : e_ns_we;
    while (!rdy && idx < 1000) begin
      if (!we_n) begin we_lo++; if (we_first < 0) we_first = idx; end
      if (!ce_n) begin ce_lo++; if (ce_first < 0) ce_first = idx; end
      if (dout_en) begin dv++; if (dv_first < 0) dv_first = idx; if (mem_dout !== d) data_bad++; end
      if (mem_addr !== a) addr_bad++;
      idx++;
      @(negedge clk);
    end
    busy = idx;
    chk(busy == (ce ? e_busy_ce : e_busy_we), "R8", "busy cycles", busy, ce ? e_busy_ce : e_busy_we);
    term = ce ? ce_lo : we_lo;
    chk(term == ns, "R4", "ending strobe low cycles", term, ns);
    chk(addr_bad == 0, "R10", "address disturbed during write", addr_bad, 0);
    chk(data_bad == 0, "R3", "wrong data while driven", data_bad, 0);
    if (ce) begin
      chk(ce_first == 1 && we_first == 1, "R6", "strobe fall cycle", ce_first * 100 + we_first, 101);
      chk(dv_first == 1, "R6", "data drive start", dv_first, 1);
      chk(we_lo == ns + e_nh, "R6", "write-enable low cycles", we_lo, ns + e_nh);
      chk(dv == ns + e_nh, "R7", "data driven cycles", dv, ns + e_nh);
    end else begin
      chk(ce_first == 0 && we_first == 1, "R5", "strobe fall cycle", ce_first * 100 + we_first, 1);
      chk(dv_first == 1 + e_float, "R5", "data drive start", dv_first, 1 + e_float);
      chk(ce_lo == 1 + ns + e_nh, "R5", "chip-enable low cycles", ce_lo, 1 + ns + e_nh);
      chk(dv == ns - e_float + e_nh, "R7", "data driven cycles", dv, ns - e_float + e_nh);
    end
    chk(we_n && ce_n && !dout_en, "R7", "all released at completion", {we_n, ce_n, dout_en}, 3'b110);
    chk(done == 1'b1, "R9", "done at ready return", done, 1);
    chk(mem_addr === a, "R3", "address kept after completion", mem_addr, a);
  endtask

  task automatic run_single(input logic [14:0] a, input logic [7:0] d, input bit ce);
    int busy;
    @(negedge clk);
    while (!rdy) @(negedge clk);
    req_valid = 1; req_addr = a; req_data = d; req_ce_mode = ce;
    @(negedge clk);
    req_valid = 0; req_addr = ~a; req_data = ~d; req_ce_mode = ~ce;
    chk(!rdy, "R2", "ready after accept", rdy, 0);
    chk(mem_addr === a, "R3", "address after accept", mem_addr, a);
    measure(a, d, ce, busy);
    @(negedge clk);
    chk(!done, "R9", "done one cycle only", done, 0);
    chk(rdy, "R2", "ready stays high when idle", rdy, 1);
  endtask

  // Second request held through the first write with a different style.
  task automatic run_back2back(input logic [14:0] a, input logic [7:0] d, input bit ce_a,
                               input logic [14:0] b, input logic [7:0] e, input bit ce_b);
    int busy_a, busy_b;
    @(negedge clk);
    while (!rdy) @(negedge clk);
    req_valid = 1; req_addr = a; req_data = d; req_ce_mode = ce_a;
    @(negedge clk);
    req_addr = b; req_data = e; req_ce_mode = ce_b;   // still requesting while busy
    measure(a, d, ce_a, busy_a);                      // R11: first write keeps its own style
    @(negedge clk);
    req_valid = 0;
    chk(mem_addr === b, "R10", "held request taken at ready return", mem_addr, b);
    chk(busy_a + 1 >= E_CYC, "R8", "address change gap", busy_a + 1, E_CYC);
    chk(busy_a + 1 == (ce_a ? e_busy_ce : e_busy_we) + 1, "R10", "gap exact", busy_a + 1,
        (ce_a ? e_busy_ce : e_busy_we) + 1);
    measure(b, e, ce_b, busy_b);
  endtask

  task automatic idle_quiet;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(rdy && we_n && ce_n && !dout_en && !done, "R2", "quiet while idle",
          {rdy, we_n, ce_n, dout_en, done}, 5'b11100);
    end
  endtask

  initial begin
    e_float   = cdiv(50);
    e_ns_we   = imax(imax(cdiv(80), cdiv(80)), e_float + cdiv(50));
    e_ns_ce   = imax(imax(cdiv(80), cdiv(80)), cdiv(50));
    e_nh      = imax(cdiv(10), cdiv(5));
    e_busy_we = 1 + e_ns_we + e_nh + imax(1, E_CYC - e_ns_we - e_nh - 2);
    e_busy_ce = 1 + e_ns_ce + e_nh + imax(1, E_CYC - e_ns_ce - e_nh - 2);

    rst = 1; req_valid = 0; req_addr = '0; req_data = '0; req_ce_mode = 0;
    repeat (4) @(negedge clk);
    chk(rdy && we_n && ce_n && !dout_en && !done, "R1", "values in reset",
        {rdy, we_n, ce_n, dout_en, done}, 5'b11100);
    rst = 0;
    @(negedge clk);
    chk(rdy && we_n && ce_n && !dout_en && !done, "R1", "values after reset",
        {rdy, we_n, ce_n, dout_en, done}, 5'b11100);
    idle_quiet();
    run_single(15'h1234, 8'hA5, 1'b0);
    run_single(15'h7FFF, 8'h3C, 1'b1);
    run_back2back(15'h0001, 8'h11, 1'b1, 15'h4002, 8'h22, 1'b1);
    run_back2back(15'h2AAA, 8'h5A, 1'b0, 15'h5555, 8'hC3, 1'b1);
    run_back2back(15'h0F0F, 8'hF0, 1'b1, 15'h7000, 8'h0F, 1'b0);
    idle_quiet();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule